// File: doc/BRIEF.md
# Register-Register Integer Execution Unit

This block is the combinational integer datapath of a 32-bit core's execute stage for register-register instructions. It receives a 4-bit operation code, two source operand values and a pair of qualifiers telling whether each source really came from a register. In the same cycle it returns one destination value, an overflow indication and an invalid-opcode indication.

Twelve operations are covered. The arithmetic group holds add, subtract, signed multiply, unsigned multiply, signed divide and unsigned divide. The logic group holds XOR, OR and AND. The shift group holds logical left, logical right and arithmetic right. A divide writes a single packed destination, with the quotient in the upper half and the remainder in the lower half. The multiplier and divider are single-cycle behavioural operators. The shifter can be built either as a logarithmic mux tree or as a plain shift operator, selected by a parameter.

When the operation cannot be executed, the result and the overflow output are held at zero so that nothing downstream picks up a partial value. This happens when a source is not a register operand or when the operation code is not defined.

Top module: `int_alu`

## Requirements
- R1: Operation codes are 0 add, 1 subtract, 2 signed multiply, 3 unsigned multiply, 4 signed divide, 5 unsigned divide, 6 XOR, 7 OR, 8 AND, 9 logical left shift, 10 logical right shift, 11 arithmetic right shift. Add gives A+B modulo 2^32 and subtract gives A-B modulo 2^32.
- R2: For add and subtract, overflow is 1 exactly when the result is signed overflow: the operands (B inverted for subtract) share a sign bit and the result's sign bit differs from A's.
- R3: Both multiplies give the low 32 bits of the product. Overflow is 1 when the full product does not fit in 32 bits, read as two's complement for signed multiply and as unsigned for unsigned multiply.
- R4: Both divides put the quotient in bits 31:16 and the remainder in bits 15:0. A signed divide truncates toward zero, and its remainder takes the dividend's sign.
- R5: A divide with a nonzero divisor sets overflow when the quotient or the remainder does not fit in 16 bits: signed 16-bit for signed divide, unsigned 16-bit for unsigned divide.
- R6: A divide by zero returns 0xFFFFFFFF with overflow set.
- R7: XOR, OR and AND give the bitwise result of A and B, and overflow is 0.
- R8: Shifts move A by B[4:0] and ignore B[31:5]. Left and logical right shifts fill with zeros, arithmetic right fills with A[31], and overflow is 0.
- R9: If either source qualifier is 0 (not a register operand), the invalid-opcode output is 1, the result is 0 and overflow is 0.
- R10: Operation codes 12 to 15 set the invalid-opcode output with result 0 and overflow 0. A defined code with both qualifiers at 1 keeps the invalid-opcode output at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select |
| src_a_reg | input | 1 | 1 when operand A comes from a register |
| src_b_reg | input | 1 | 1 when operand B comes from a register |
| opnd_a | input | 32 | First source value |
| opnd_b | input | 32 | Second source value, or the shift amount |
| result | output | 32 | Destination value |
| ovf | output | 1 | Overflow or underflow of the executed operation |
| bad_op | output | 1 | Invalid-opcode exception |

## Verification
Add and subtract are driven with small values, with operands that cross the signed limit in each direction, and with a negative result that must not raise the flag. This separates true signed overflow from an ordinary borrow. The multiply cases use the same operand bit patterns under both signed and unsigned codes, so a mix-up in operand extension or in the overflow width shows up. The divide cases mix dividend and divisor signs, a quotient that does not fit the half field, the most negative value divided by minus one, and a zero divisor. Shift amounts above 31 and sign-bit sources separate the zero fill from the sign fill and show whether the upper bits of the amount are masked.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_MUL  = 4'd2,
      OP_MULU = 4'd3,
      OP_DIV  = 4'd4,
      OP_DIVU = 4'd5,
      OP_XOR  = 4'd6,
      OP_OR   = 4'd7,
      OP_AND  = 4'd8,
      OP_LSL  = 4'd9,
      OP_LSR  = 4'd10,
      OP_ASR  = 4'd11
   } alu_op_e;

   localparam int unsigned OP_COUNT = 12;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int unsigned W = 32
) (
   input  logic         sub,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         ovf
);
   logic [W-1:0] b_eff;

   always_comb begin
      b_eff = sub ? ~b : b;
      sum   = a + b_eff + {{(W-1){1'b0}}, sub};
      ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
   end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
   parameter int unsigned W = 32
) (
   input  logic         is_signed,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] mul_res,
   output logic         mul_ovf,
   output logic [W-1:0] div_res,
   output logic         div_ovf
);
   localparam int unsigned H  = W / 2;
   localparam int unsigned XW = W + 1;
   localparam int unsigned PW = 2 * XW;

   logic signed [XW-1:0] xa, xb, xb_safe, quo, rem;
   logic signed [PW-1:0] prod;
   logic                 div_zero, quo_fits, rem_fits;

   always_comb begin
      // one extra bit lets signed and unsigned share one operator
      xa      = $signed({is_signed & a[W-1], a});
      xb      = $signed({is_signed & b[W-1], b});
      div_zero = (b == '0);
      xb_safe = div_zero ? XW'(1) : xb;

      prod    = xa * xb;
      mul_res = prod[W-1:0];
      if (is_signed) mul_ovf = !((&prod[PW-1:W-1]) || !(|prod[PW-1:W-1]));
      else           mul_ovf = |prod[PW-1:W];

      quo = xa / xb_safe;
      rem = xa % xb_safe;
      if (is_signed) begin
         quo_fits = (&quo[XW-1:H-1]) || !(|quo[XW-1:H-1]);
         rem_fits = (&rem[XW-1:H-1]) || !(|rem[XW-1:H-1]);
      end else begin
         quo_fits = !(|quo[XW-1:H]);
         rem_fits = !(|rem[XW-1:H]);
      end
      if (div_zero) begin
         div_res = '1;
         div_ovf = 1'b1;
      end else begin
         div_res = {quo[H-1:0], rem[H-1:0]};
         div_ovf = !(quo_fits && rem_fits);
      end
   end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int unsigned W      = 32,
   parameter bit          BARREL = 1'b1,
   localparam int unsigned SW    = $clog2(W)
) (
   input  logic          arith,
   input  logic [W-1:0]  a,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  left,
   output logic [W-1:0]  right
);
   logic fill;
   assign fill = arith & a[W-1];

   if (BARREL) begin : g_tree
      logic [W-1:0] ls [0:SW];
      logic [W-1:0] rs [0:SW];
      assign ls[0] = a;
      assign rs[0] = a;
      for (genvar k = 0; k < SW; k++) begin : g_stage
         localparam int unsigned D = 1 << k;
         assign ls[k+1] = amt[k] ? {ls[k][W-1-D:0], {D{1'b0}}} : ls[k];
         assign rs[k+1] = amt[k] ? {{D{fill}}, rs[k][W-1:D]}   : rs[k];
      end
      assign left  = ls[SW];
      assign right = rs[SW];
   end else begin : g_op
      logic signed [W:0] ext;
      logic signed [W:0] shr;
      assign ext   = $signed({fill, a});
      assign shr   = ext >>> amt;
      assign left  = a << amt;
      assign right = shr[W-1:0];
   end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
   parameter int unsigned DATA_W = 32,
   parameter bit          BARREL = 1'b1,
   localparam int unsigned SHW    = $clog2(DATA_W)
) (
   input  logic              [3:0] op_code,
   input  logic                    src_a_reg,
   input  logic                    src_b_reg,
   input  logic [DATA_W-1:0]       opnd_a,
   input  logic [DATA_W-1:0]       opnd_b,
   output logic [DATA_W-1:0]       result,
   output logic                    ovf,
   output logic                    bad_op
);
   import alu_pkg::*;

   if (DATA_W < 8 || (DATA_W % 2) != 0 || (1 << SHW) != DATA_W) begin : g_bad_w
      $error("int_alu: DATA_W must be a power of two of at least 8");
   end

   logic [DATA_W-1:0] as_sum, mul_res, div_res, sh_left, sh_right;
   logic              as_ovf, mul_ovf, div_ovf, is_signed_md;
   logic              op_known;

   assign op_known     = (op_code < 4'(OP_COUNT));
   assign is_signed_md = (op_code == OP_MUL) || (op_code == OP_DIV);

   alu_addsub #(.W(DATA_W)) u_addsub (
      .sub (op_code == OP_SUB),
      .a   (opnd_a),
      .b   (opnd_b),
      .sum (as_sum),
      .ovf (as_ovf)
   );

   alu_muldiv #(.W(DATA_W)) u_muldiv (
      .is_signed (is_signed_md),
      .a         (opnd_a),
      .b         (opnd_b),
      .mul_res   (mul_res),
      .mul_ovf   (mul_ovf),
      .div_res   (div_res),
      .div_ovf   (div_ovf)
   );

   alu_shift #(.W(DATA_W), .BARREL(BARREL)) u_shift (
      .arith (op_code == OP_ASR),
      .a     (opnd_a),
      .amt   (opnd_b[SHW-1:0]),
      .left  (sh_left),
      .right (sh_right)
   );

   always_comb begin
      bad_op = !op_known || !src_a_reg || !src_b_reg;
      result = '0;
      ovf    = 1'b0;
      if (!bad_op) begin
         case (alu_op_e'(op_code))
            OP_ADD, OP_SUB:  begin result = as_sum;  ovf = as_ovf;  end
            OP_MUL, OP_MULU: begin result = mul_res; ovf = mul_ovf; end
            OP_DIV, OP_DIVU: begin result = div_res; ovf = div_ovf; end
            OP_XOR:          result = opnd_a ^ opnd_b;
            OP_OR:           result = opnd_a | opnd_b;
            OP_AND:          result = opnd_a & opnd_b;
            OP_LSL:          result = sh_left;
            OP_LSR, OP_ASR:  result = sh_right;
            default:         result = '0;
         endcase
      end
   end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic [3:0]        op_code,
   input logic              src_a_reg,
   input logic              src_b_reg,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [DATA_W-1:0] result,
   input logic              ovf,
   input logic              bad_op
);
   always_comb begin
      if (!$isunknown({op_code, src_a_reg, src_b_reg, opnd_a, opnd_b})) begin
         // R9
         if (!src_a_reg || !src_b_reg)
            nonreg_trap_chk: assert (bad_op && result == '0 && !ovf);
         // R10
         if (op_code >= 4'd12)
            undef_trap_chk: assert (bad_op && result == '0 && !ovf);
         // R10
         if (op_code < 4'd12 && src_a_reg && src_b_reg)
            legal_op_chk: assert (!bad_op);
         // R1
         if (!bad_op && op_code == 4'd0)
            add_inverse_chk: assert (result - opnd_b == opnd_a);
         // R7
         if (!bad_op && op_code >= 4'd6)
            no_overflow_chk: assert (!ovf);
         // R6
         if (!bad_op && (op_code == 4'd4 || op_code == 4'd5) && opnd_b == '0)
            div_zero_chk: assert (ovf && (&result));
      end
   end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_int_alu_chk (
   .op_code   (op_code),
   .src_a_reg (src_a_reg),
   .src_b_reg (src_b_reg),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .result    (result),
   .ovf       (ovf),
   .bad_op    (bad_op)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;
   logic        clk = 1'b0;
   logic [3:0]  op_code = 4'd0;
   logic        src_a_reg = 1'b1, src_b_reg = 1'b1;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic [31:0] result;
   logic        ovf, bad_op;
   int          checks = 0, failures = 0;

   always #5 clk = ~clk;

   int_alu dut (
      .op_code(op_code), .src_a_reg(src_a_reg), .src_b_reg(src_b_reg),
      .opnd_a(opnd_a), .opnd_b(opnd_b),
      .result(result), .ovf(ovf), .bad_op(bad_op)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      op_code = op; opnd_a = a; opnd_b = b;
      @(negedge clk);
   endtask

   task automatic expect_op(input string req, input logic [3:0] op, input logic [31:0] a,
                            input logic [31:0] b, input logic [31:0] exp_r, input logic exp_v);
      run(op, a, b);
      check(req, result, exp_r);
      check({req, " ovf"}, {31'd0, ovf}, {31'd0, exp_v});
      check({req, " bad_op"}, {31'd0, bad_op}, 32'd0);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      check("R1 idle add", result, 32'd0);
      check("R10 idle bad_op", {31'd0, bad_op}, 32'd0);
   endtask

   task automatic t_addsub();
      expect_op("R1 add", 4'd0, 32'd5, 32'd7, 32'd12, 1'b0);
      expect_op("R1 sub neg", 4'd1, 32'd3, 32'd5, 32'hFFFF_FFFE, 1'b0);
      expect_op("R2 add ovf", 4'd0, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 1'b1);
      expect_op("R2 sub ovf", 4'd1, 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, 1'b1);
      expect_op("R2 add neg no ovf", 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0);
   endtask

   task automatic t_mul();
      expect_op("R3 mul signed", 4'd2, 32'hFFFF_FFFD, 32'd5, 32'hFFFF_FFF1, 1'b0);
      expect_op("R3 mul signed -1*2", 4'd2, 32'hFFFF_FFFF, 32'd2, 32'hFFFF_FFFE, 1'b0);
      expect_op("R3 mulu wide", 4'd3, 32'hFFFF_FFFF, 32'd2, 32'hFFFF_FFFE, 1'b1);
      expect_op("R3 mul ovf", 4'd2, 32'h0001_0000, 32'h0001_0000, 32'd0, 1'b1);
      expect_op("R3 mul 2^30*2", 4'd2, 32'h4000_0000, 32'd2, 32'h8000_0000, 1'b1);
      expect_op("R3 mulu 2^30*2", 4'd3, 32'h4000_0000, 32'd2, 32'h8000_0000, 1'b0);
   endtask

   task automatic t_div();
      expect_op("R4 divu", 4'd5, 32'd1000, 32'd7, {16'd142, 16'd6}, 1'b0);
      expect_op("R4 div neg", 4'd4, -32'sd100, 32'd7, {16'hFFF2, 16'hFFFE}, 1'b0);
      expect_op("R4 div neg divisor", 4'd4, 32'd100, -32'sd7, {16'hFFF2, 16'd2}, 1'b0);
      expect_op("R5 divu quo wide", 4'd5, 32'h0001_0000, 32'd1, 32'd0, 1'b1);
      expect_op("R5 div -2^31/-1", 4'd4, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 1'b1);
      expect_op("R5 div rem wide", 4'd4, 32'd40000, 32'd50000, {16'd0, 16'h9C40}, 1'b1);
      expect_op("R5 divu rem fits", 4'd5, 32'd40000, 32'd50000, {16'd0, 16'h9C40}, 1'b0);
      expect_op("R6 div zero", 4'd4, 32'd123, 32'd0, 32'hFFFF_FFFF, 1'b1);
      expect_op("R6 divu zero", 4'd5, 32'd0, 32'd0, 32'hFFFF_FFFF, 1'b1);
   endtask

   task automatic t_logic();
      expect_op("R7 xor", 4'd6, 32'hF0F0_1234, 32'hFF00_FFFF, 32'h0FF0_EDCB, 1'b0);
      expect_op("R7 or", 4'd7, 32'hF0F0_0000, 32'h0F00_00FF, 32'hFFF0_00FF, 1'b0);
      expect_op("R7 and", 4'd8, 32'hF0F0_FFFF, 32'h0FF0_1234, 32'h00F0_1234, 1'b0);
   endtask

   task automatic t_shift();
      expect_op("R8 lsl masked amt", 4'd9, 32'd1, 32'd33, 32'd2, 1'b0);
      expect_op("R8 lsl 31", 4'd9, 32'h0000_0003, 32'd31, 32'h8000_0000, 1'b0);
      expect_op("R8 lsr 31", 4'd10, 32'h8000_0000, 32'd31, 32'd1, 1'b0);
      expect_op("R8 asr sign", 4'd11, 32'h8000_0000, 32'd4, 32'hF800_0000, 1'b0);
      expect_op("R8 asr pos", 4'd11, 32'h4000_0000, 32'd30, 32'd1, 1'b0);
      expect_op("R8 asr zero amt", 4'd11, 32'h8765_4321, 32'hFFFF_FFE0, 32'h8765_4321, 1'b0);
   endtask

   task automatic t_invalid();
      src_a_reg = 1'b0;
      run(4'd0, 32'h7FFF_FFFF, 32'd1);
      check("R9 a not reg result", result, 32'd0);
      check("R9 a not reg ovf", {31'd0, ovf}, 32'd0);
      check("R9 a not reg bad_op", {31'd0, bad_op}, 32'd1);
      src_a_reg = 1'b1; src_b_reg = 1'b0;
      run(4'd4, 32'd5, 32'd0);
      check("R9 b not reg result", result, 32'd0);
      check("R9 b not reg bad_op", {31'd0, bad_op}, 32'd1);
      src_b_reg = 1'b1;
      for (int c = 12; c < 16; c++) begin
         run(4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
         check("R10 undef result", result, 32'd0);
         check("R10 undef ovf", {31'd0, ovf}, 32'd0);
         check("R10 undef bad_op", {31'd0, bad_op}, 32'd1);
      end
   endtask

   initial begin
      t_reset_state();
      t_addsub();
      t_mul();
      t_div();
      t_logic();
      t_shift();
      t_invalid();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule